// File: doc/BRIEF.md
# Repeated String Compare and Scan Engine

This engine carries out one activation of a repeated string comparison. In compare mode it reads one element from a source stream and one from a destination stream, then subtracts the destination element from the source element. In scan mode it reads destination elements and subtracts each one from an accumulator value. Every subtraction updates a set of arithmetic flags. The zero result, together with the remaining count, decides whether the repetition goes on. A repeat-condition input picks the termination rule: continue while equal, or continue while not equal.

Each activation works at a byte, word or doubleword width. It steps both indices up or down by the element size and decrements the count. It reports the updated count and indices, the flags, and a restart indication. The surrounding sequencer uses restart to re-enter the same operation. A compare activation handles at most one element. A scan activation keeps going until one of these happens: the count runs out, the zero condition fails, a single-step (trap) request stops it after one element, or an accumulated cycle cost goes past a selectable budget. In 16-bit address mode only the low 16 bits of the count and the indices take part, and the upper bits are kept.

Memory reads go through a request/acknowledge port. A segment-select output tells the port which stream is being read. The request stays asserted until it is acknowledged.

Top module: `rce_engine`

## Requirements
- R1: If the count is zero when `start` arrives (only the low 16 bits are considered when `addr_wide`=0), no memory read is issued. The flags, count and indices stay as they were, `restart` is 0, and `cost_used` is 0.
- R2: In compare mode (`op_scan`=0) the engine reads the source element (`mem_seg`=0, address `src`) and then the destination element (`mem_seg`=1, address `dst`). It sets the flags from source minus destination and processes exactly one element per activation.
- R3: In scan mode (`op_scan`=1) every read targets the destination (`mem_seg`=1, address `dst`). Flags come from accumulator minus element. The source index does not change.
- R4: `flags_o` bit 0 is the borrow (carry) flag. Bit 1 is even parity of the low result byte. Bit 2 is the carry out of bit 3 (auxiliary). Bit 3 is zero. Bit 4 is the sign bit of the result. Bit 5 is signed overflow. All of them are computed at the element width (`elem_size` 0=byte, 1=word, 2=doubleword), and operand bits above that width are ignored.
- R5: After each element the indices move by 1, 2 or 4: downward when `dir_down`=1, upward otherwise. The count decrements by one.
- R6: With `addr_wide`=0 the count and index arithmetic wraps within the low 16 bits, and bits above 15 keep their values. With `addr_wide`=1 the full width takes part.
- R7: A scan continues only while the count is nonzero and the zero flag equals `rep_equal` (1 = continue while equal, 0 = continue while not equal). The zero condition starts equal to `rep_equal`.
- R8: Each scan element costs 5 cycles (`fast_core`=1) or 8 cycles (`fast_core`=0). The scan stops after the element that takes the accumulated cost strictly above 100 (`big_budget`=0) or 1000 (`big_budget`=1). The total appears on `cost_used`.
- R9: With `trap`=1 a scan processes exactly one element.
- R10: `restart` is 1 in the `done` cycle exactly when the final count is nonzero and the last zero condition still equals `rep_equal`.
- R11: `done` is a one-cycle pulse. `mem_req` is only asserted while `busy`, and it is held with a stable address and segment until `mem_ack`.
- R12: A compare element costs 7 cycles (`fast_core`=1) or 9 cycles (`fast_core`=0), reported on `cost_used`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an activation (ignored while busy) |
| op_scan | input | 1 | 0 = compare, 1 = scan |
| elem_size | input | 2 | 0 byte, 1 word, 2 doubleword |
| addr_wide | input | 1 | 1 = full-width count/indices, 0 = 16-bit |
| rep_equal | input | 1 | Repeat condition: 1 while equal, 0 while not equal |
| fast_core | input | 1 | Selects the lower per-element cost |
| big_budget | input | 1 | Selects the 1000-cycle scan budget |
| trap | input | 1 | Single-step: scan stops after one element |
| dir_down | input | 1 | Indices decrement when 1 |
| count_i | input | ADDR_W | Initial count |
| src_i | input | ADDR_W | Initial source index |
| dst_i | input | ADDR_W | Initial destination index |
| acc_i | input | 32 | Accumulator for scan |
| mem_req | output | 1 | Read request |
| mem_seg | output | 1 | 0 = source stream, 1 = destination stream |
| mem_addr | output | ADDR_W | Read index |
| mem_size | output | 2 | Element size of the read |
| mem_rdata | input | 32 | Read data, element in low bits |
| mem_ack | input | 1 | Read acknowledge, data valid |
| busy | output | 1 | Activation in progress |
| done | output | 1 | One-cycle completion pulse |
| restart | output | 1 | Re-enter the operation (valid with done) |
| count_o | output | ADDR_W | Current count |
| src_o | output | ADDR_W | Current source index |
| dst_o | output | ADDR_W | Current destination index |
| flags_o | output | 6 | Flags of the last subtraction |
| cost_used | output | CYC_W | Cycle cost accumulated in this activation |

## Verification
The properties assume that `mem_ack` is only meaningful while `mem_req` is high and that `mem_rdata` is valid in the acknowledge cycle. They also assume that `start` is pulsed only while the engine is idle and that `elem_size` never takes the value 3. The stimulus issues each activation from idle with a legal size code and waits for `done` before the next one. A memory model answers the requests, sometimes at once and sometimes after pseudo-random wait cycles, so the held-request property is exercised without the acknowledge ever arriving early.

// File: rtl/rce_pkg.sv
package rce_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2
   } rce_size_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD_SRC,
      ST_RD_DST,
      ST_FIN
   } rce_state_e;

   // bit 5 .. bit 0 : overflow, sign, zero, aux, parity, borrow
   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
      logic aux;
      logic par;
      logic brw;
   } rce_flags_t;

   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_bytes = 3'd1;
         SZ_WORD: size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

   function automatic logic [31:0] size_mask(input logic [1:0] sz, input logic [31:0] v);
      case (sz)
         SZ_BYTE: size_mask = {24'd0, v[7:0]};
         SZ_WORD: size_mask = {16'd0, v[15:0]};
         default: size_mask = v;
      endcase
   endfunction

endpackage

// File: rtl/rce_sub_flags.sv
module rce_sub_flags
   import rce_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output rce_flags_t   flags
);
   if (W < 8) begin : g_bad_w
      $error("rce_sub_flags: W must be at least 8");
   end

   logic [W:0]   diff;
   logic [W-1:0] res;

   assign diff = {1'b0, a} - {1'b0, b};
   assign res  = diff[W-1:0];

   always_comb begin
      flags.brw = diff[W];
      flags.zro = (res == '0);
      flags.sgn = res[W-1];
      flags.ovf = (a[W-1] ^ b[W-1]) & (res[W-1] ^ a[W-1]);
      flags.par = ~^res[7:0];
      flags.aux = a[4] ^ b[4] ^ res[4];
   end
endmodule

// File: rtl/rce_index_step.sv
module rce_index_step
   import rce_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] cur,
   input  logic [1:0]   size,
   input  logic         down,
   input  logic         wide,
   output logic [W-1:0] nxt
);
   logic [W-1:0] step;
   logic [W-1:0] full;

   assign step = W'(size_bytes(size));
   assign full = down ? (cur - step) : (cur + step);

   if (W > 16) begin : g_split
      assign nxt = wide ? full : {cur[W-1:16], full[15:0]};
   end else begin : g_flat
      logic unused_wide;
      assign unused_wide = wide;
      assign nxt = full;
   end
endmodule

// File: rtl/rce_budget.sv
module rce_budget #(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          add_en,
   input  logic [CW-1:0] cost,
   input  logic [CW-1:0] limit,
   output logic [CW-1:0] used,
   output logic          over
);
   logic [CW:0] sum;

   assign sum  = {1'b0, used} + {1'b0, cost};
   assign over = sum > {1'b0, limit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      used <= '0;
      else if (clear)  used <= '0;
      else if (add_en) used <= sum[CW-1:0];
   end
endmodule

// File: rtl/rce_engine.sv
module rce_engine
   import rce_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int CYC_W          = 11,
   parameter int BUDGET_LO      = 100,
   parameter int BUDGET_HI      = 1000,
   parameter int COST_CMP_FAST  = 7,
   parameter int COST_CMP_SLOW  = 9,
   parameter int COST_SCAN_FAST = 5,
   parameter int COST_SCAN_SLOW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_scan,
   input  logic [1:0]        elem_size,
   input  logic              addr_wide,
   input  logic              rep_equal,
   input  logic              fast_core,
   input  logic              big_budget,
   input  logic              trap,
   input  logic              dir_down,
   input  logic [ADDR_W-1:0] count_i,
   input  logic [ADDR_W-1:0] src_i,
   input  logic [ADDR_W-1:0] dst_i,
   input  logic [31:0]       acc_i,
   output logic              mem_req,
   output logic              mem_seg,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   output logic              busy,
   output logic              done,
   output logic              restart,
   output logic [ADDR_W-1:0] count_o,
   output logic [ADDR_W-1:0] src_o,
   output logic [ADDR_W-1:0] dst_o,
   output logic [5:0]        flags_o,
   output logic [CYC_W-1:0]  cost_used
);
   localparam int COST_MAX_A = (COST_CMP_SLOW > COST_CMP_FAST) ? COST_CMP_SLOW : COST_CMP_FAST;
   localparam int COST_MAX_B = (COST_SCAN_SLOW > COST_SCAN_FAST) ? COST_SCAN_SLOW : COST_SCAN_FAST;
   localparam int COST_MAX   = (COST_MAX_A > COST_MAX_B) ? COST_MAX_A : COST_MAX_B;
   localparam int N_WIDTHS   = 3;
   localparam int N_PTRS     = 3;
   localparam logic [CYC_W-1:0] LIM_LO = CYC_W'(BUDGET_LO);
   localparam logic [CYC_W-1:0] LIM_HI = CYC_W'(BUDGET_HI);

   if (ADDR_W < 16) begin : g_bad_addr
      $error("rce_engine: ADDR_W must be at least 16");
   end
   if ((64'd1 << CYC_W) <= 64'(BUDGET_HI + COST_MAX)) begin : g_bad_cyc
      $error("rce_engine: CYC_W too narrow for budget plus one element");
   end
   if (BUDGET_LO > BUDGET_HI) begin : g_bad_budget
      $error("rce_engine: BUDGET_LO must not exceed BUDGET_HI");
   end

   rce_state_e        state;
   logic              op_q, wide_q, rep_q, fast_q, big_q, trap_q, down_q;
   logic [1:0]        sz_q;
   logic [31:0]       acc_q, opa_q;
   logic [ADDR_W-1:0] cnt_q, src_q, dst_q;
   rce_flags_t        flags_q;
   logic              zc_q;

   // ---------------- operand path ----------------
   logic [31:0] rd_m, op_a;
   rce_flags_t  fl_w [N_WIDTHS];
   rce_flags_t  alu_fl;

   assign rd_m = size_mask(sz_q, mem_rdata);
   assign op_a = op_q ? size_mask(sz_q, acc_q) : opa_q;

   for (genvar k = 0; k < N_WIDTHS; k++) begin : g_width
      localparam int W = 8 << k;
      rce_sub_flags #(.W(W)) u_sub (
         .a     (op_a[W-1:0]),
         .b     (rd_m[W-1:0]),
         .flags (fl_w[k])
      );
   end

   always_comb begin
      case (sz_q)
         SZ_BYTE: alu_fl = fl_w[0];
         SZ_WORD: alu_fl = fl_w[1];
         default: alu_fl = fl_w[2];
      endcase
   end

   // ---------------- index / count steppers ----------------
   logic [ADDR_W-1:0] ptr_cur [N_PTRS];
   logic [ADDR_W-1:0] ptr_nxt [N_PTRS];

   assign ptr_cur[0] = src_q;
   assign ptr_cur[1] = dst_q;
   assign ptr_cur[2] = cnt_q;

   for (genvar p = 0; p < N_PTRS; p++) begin : g_ptr
      if (p == N_PTRS - 1) begin : g_count
         rce_index_step #(.W(ADDR_W)) u_step (
            .cur  (ptr_cur[p]),
            .size (SZ_BYTE),
            .down (1'b1),
            .wide (wide_q),
            .nxt  (ptr_nxt[p])
         );
      end else begin : g_index
         rce_index_step #(.W(ADDR_W)) u_step (
            .cur  (ptr_cur[p]),
            .size (sz_q),
            .down (down_q),
            .wide (wide_q),
            .nxt  (ptr_nxt[p])
         );
      end
   end

   // ---------------- cost budget ----------------
   logic [CYC_W-1:0] cost_sel, limit_sel;
   logic             over_next, elem_done, clr_budget;

   always_comb begin
      if (op_q) cost_sel = fast_q ? CYC_W'(COST_SCAN_FAST) : CYC_W'(COST_SCAN_SLOW);
      else      cost_sel = fast_q ? CYC_W'(COST_CMP_FAST)  : CYC_W'(COST_CMP_SLOW);
   end
   assign limit_sel  = big_q ? LIM_HI : LIM_LO;
   assign elem_done  = (state == ST_RD_DST) && mem_ack;
   assign clr_budget = (state == ST_IDLE) && start;

   rce_budget #(.CW(CYC_W)) u_budget (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (clr_budget),
      .add_en (elem_done),
      .cost   (cost_sel),
      .limit  (limit_sel),
      .used   (cost_used),
      .over   (over_next)
   );

   // ---------------- control ----------------
   logic in_cnt_nz, cnt_nz, nxt_cnt_nz, keep_going;

   assign in_cnt_nz  = addr_wide ? (count_i != '0) : (count_i[15:0] != 16'd0);
   assign cnt_nz     = wide_q ? (cnt_q != '0) : (cnt_q[15:0] != 16'd0);
   assign nxt_cnt_nz = wide_q ? (ptr_nxt[2] != '0) : (ptr_nxt[2][15:0] != 16'd0);
   assign keep_going = op_q && nxt_cnt_nz && (alu_fl.zro == rep_q) && !trap_q && !over_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= 1'b0;
         wide_q  <= 1'b0;
         rep_q   <= 1'b0;
         fast_q  <= 1'b0;
         big_q   <= 1'b0;
         trap_q  <= 1'b0;
         down_q  <= 1'b0;
         sz_q    <= SZ_BYTE;
         acc_q   <= '0;
         opa_q   <= '0;
         cnt_q   <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         flags_q <= '0;
         zc_q    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               op_q   <= op_scan;
               wide_q <= addr_wide;
               rep_q  <= rep_equal;
               fast_q <= fast_core;
               big_q  <= big_budget;
               trap_q <= trap;
               down_q <= dir_down;
               sz_q   <= elem_size;
               acc_q  <= acc_i;
               cnt_q  <= count_i;
               src_q  <= src_i;
               dst_q  <= dst_i;
               zc_q   <= rep_equal;
               if (!in_cnt_nz) state <= ST_FIN;
               else            state <= op_scan ? ST_RD_DST : ST_RD_SRC;
            end
            ST_RD_SRC: if (mem_ack) begin
               opa_q <= rd_m;
               state <= ST_RD_DST;
            end
            ST_RD_DST: if (mem_ack) begin
               flags_q <= alu_fl;
               zc_q    <= alu_fl.zro;
               if (!op_q) src_q <= ptr_nxt[0];
               dst_q   <= ptr_nxt[1];
               cnt_q   <= ptr_nxt[2];
               state   <= keep_going ? ST_RD_DST : ST_FIN;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req  = (state == ST_RD_SRC) || (state == ST_RD_DST);
   assign mem_seg  = (state == ST_RD_DST);
   assign mem_addr = (state == ST_RD_SRC) ? src_q : dst_q;
   assign mem_size = sz_q;
   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_FIN);
   assign restart  = done && cnt_nz && (zc_q == rep_q);
   assign count_o  = cnt_q;
   assign src_o    = src_q;
   assign dst_o    = dst_q;
   assign flags_o  = flags_q;
endmodule

// File: rtl/rce_checker.sv
module rce_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_seg,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              done,
   input logic              restart,
   input logic              busy,
   input logic [ADDR_W-1:0] count_o,
   input logic              op_q
);
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_seg));

   p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_restart_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> done && (count_o != '0));

   p_scan_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && op_q |-> mem_seg);

   p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_seg && mem_ack |=> count_o[15:0] == $past(count_o[15:0]) - 16'd1);

   p_cmp_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_seg && mem_ack && !op_q |=> !mem_req && done);
endmodule

bind rce_engine rce_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_rce_engine.sv
module sim_rce_engine;
   localparam int AW = 32;
   localparam int CW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, op_scan = 1'b0, addr_wide = 1'b1, rep_equal = 1'b0;
   logic          fast_core = 1'b0, big_budget = 1'b0, trap = 1'b0, dir_down = 1'b0;
   logic [1:0]    elem_size = 2'd0;
   logic [AW-1:0] count_i = '0, src_i = '0, dst_i = '0;
   logic [31:0]   acc_i = '0;
   logic          mem_req, mem_seg, mem_ack, busy, done, restart;
   logic [AW-1:0] mem_addr, count_o, src_o, dst_o;
   logic [1:0]    mem_size;
   logic [31:0]   mem_rdata;
   logic [5:0]    flags_o;
   logic [CW-1:0] cost_used;

   always #2 clk = ~clk;

   rce_engine u0 (.*);

   logic [31:0] smem [256];
   logic [31:0] dmem [256];
   logic        stall = 1'b0, ack_en = 1'b1;
   logic [7:0]  lfsr = 8'h5a;

   assign mem_rdata = mem_seg ? dmem[mem_addr[7:0]] : smem[mem_addr[7:0]];
   assign mem_ack   = mem_req & ack_en;

   always @(posedge clk) begin
      lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ack_en <= stall ? lfsr[0] : 1'b1;
   end

   int checks = 0, errors = 0;
   logic [AW:0] expq [$];
   logic [5:0]  exp_flags = '0;
   string       cur_tag = "R0";

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // reference flags, computed with integer arithmetic at the element width
   function automatic logic [5:0] ref_flags(logic [31:0] a, logic [31:0] b, int nbytes);
      longint m, aa, bb, r;
      int top, ones;
      logic cf, zf, sf, of, pf, af;
      m   = (64'd1 << (8 * nbytes)) - 1;
      aa  = a & m;
      bb  = b & m;
      r   = (aa - bb) & m;
      top = 8 * nbytes - 1;
      cf  = aa < bb;
      zf  = (r == 0);
      sf  = r[top];
      of  = (aa[top] != bb[top]) && (r[top] != aa[top]);
      ones = 0;
      for (int i = 0; i < 8; i++) ones += int'(r[i]);
      pf  = (ones % 2) == 0;
      af  = r[4] ^ aa[4] ^ bb[4];
      return {of, sf, zf, af, pf, cf};
   endfunction

   function automatic logic [31:0] adv(logic [31:0] v, int n, bit down, bit wide);
      logic [31:0] f;
      f = down ? v - 32'(n) : v + 32'(n);
      return wide ? f : {v[31:16], f[15:0]};
   endfunction

   function automatic bit nz(logic [31:0] c, bit wide);
      return wide ? (c != 0) : (c[15:0] != 0);
   endfunction

   // access monitor: every granted read is compared against the predicted stream
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_ack) begin
         if (expq.size() == 0) begin
            chk(1'b0, cur_tag, "unexpected read (R1/R2/R3)", {mem_seg, mem_addr}, 0);
         end else begin
            logic [AW:0] e;
            e = expq.pop_front();
            chk({mem_seg, mem_addr} == e, cur_tag, "read seg/addr (R2/R3)", {mem_seg, mem_addr}, e);
         end
      end
   end

   task automatic run_op(string tag, bit scan, logic [1:0] sz, bit wide, bit rep, bit fast,
                         bit big, bit trp, bit down, logic [31:0] cnt, logic [31:0] src,
                         logic [31:0] dst, logic [31:0] acc);
      int nb, used, cost, lim;
      logic [31:0] c, s, d, a, b;
      bit zc, rs;
      nb   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      cost = scan ? (fast ? 5 : 8) : (fast ? 7 : 9);
      lim  = big ? 1000 : 100;
      c = cnt; s = src; d = dst; used = 0; zc = rep;
      expq.delete();
      while (nz(c, wide) && zc == rep) begin
         if (!scan) begin
            expq.push_back({1'b0, s});
            a = smem[s[7:0]];
         end else begin
            a = acc;
         end
         expq.push_back({1'b1, d});
         b = dmem[d[7:0]];
         exp_flags = ref_flags(a, b, nb);
         zc = exp_flags[3];
         if (!scan) s = adv(s, nb, down, wide);
         d = adv(d, nb, down, wide);
         c = adv(c, 1, 1'b1, wide);
         used += cost;
         if (!scan || trp || used > lim) break;
      end
      rs = nz(c, wide) && (zc == rep);
      cur_tag = tag;

      @(negedge clk);
      op_scan = scan; elem_size = sz; addr_wide = wide; rep_equal = rep;
      fast_core = fast; big_budget = big; trap = trp; dir_down = down;
      count_i = cnt; src_i = src; dst_i = dst; acc_i = acc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);

      chk(count_o == c, tag, "count (R5/R6)", count_o, c);
      chk(src_o == s, tag, "src index (R5/R6)", src_o, s);
      chk(dst_o == d, tag, "dst index (R5/R6)", dst_o, d);
      chk(flags_o == exp_flags, tag, "flags (R4)", flags_o, exp_flags);
      chk(restart == rs, tag, "restart (R10)", restart, rs);
      chk(int'(cost_used) == used, tag, "cost (R8/R12)", cost_used, used);
      chk(expq.size() == 0, tag, "reads missing (R2/R3/R7)", expq.size(), 0);
      @(negedge clk);
      chk(!done && !busy, tag, "done pulse (R11)", {done, busy}, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(1'b0, "R11", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 256; i++) begin
         smem[i] = {8'(i), 8'(i), 8'(i), 8'(i)};
         dmem[i] = {8'hC3, 8'h3C, 8'h96, 8'(i)};
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_req && !restart, "R11", "reset outputs", {busy, done, mem_req, restart}, 0);
      chk(flags_o == 6'd0 && cost_used == '0, "R4", "reset flags", flags_o, 0);

      // R2: compare bytes equal in low byte only, continue-while-equal
      smem[8'h10] = 32'h123456AA; dmem[8'h40] = 32'h987654AA;
      run_op("R2", 0, 2'd0, 1, 1, 0, 0, 0, 0, 32'd5, 32'h10, 32'h40, 32'h0);
      // R4: byte 0x80 - 0x01 gives signed overflow
      smem[8'h20] = 32'h00000080; dmem[8'h60] = 32'h00000001;
      run_op("R4", 0, 2'd0, 1, 0, 1, 0, 0, 0, 32'd3, 32'h20, 32'h60, 32'h0);
      // R4: word 0x0000 - 0x0001 gives borrow, sign, aux; downward, fast core
      smem[8'h30] = 32'hFFFF0000; dmem[8'h70] = 32'h00000001;
      run_op("R12", 0, 2'd1, 1, 1, 1, 0, 0, 1, 32'd7, 32'h30, 32'h70, 32'h0);
      // R1: zero count, flags keep previous value, no reads
      run_op("R1", 1, 2'd0, 1, 1, 0, 0, 0, 0, 32'd0, 32'h5, 32'h6, 32'h0);
      // R5: compare doubleword downward with wait states
      stall = 1'b1;
      run_op("R5", 0, 2'd2, 1, 0, 0, 0, 0, 1, 32'd9, 32'h44, 32'h88, 32'h0);
      stall = 1'b0;
      // R7: byte scan while not equal finds the match at the fourth element
      run_op("R7", 1, 2'd0, 1, 0, 0, 0, 0, 0, 32'd10, 32'h0, 32'h80, 32'h00000083);
      // R7: word scan while equal stops on the fourth (mismatching) element
      dmem[8'h20] = 32'h1111BEEF; dmem[8'h22] = 32'h2222BEEF;
      dmem[8'h24] = 32'h3333BEEF; dmem[8'h26] = 32'h0000BEEE;
      stall = 1'b1;
      run_op("R7", 1, 2'd1, 1, 1, 1, 0, 0, 0, 32'd20, 32'h0, 32'h20, 32'hFFFFBEEF);
      stall = 1'b0;
      // R7: doubleword scan while equal runs the count out
      for (int i = 0; i < 4; i++) dmem[8'h50 + 4 * i] = 32'hCAFEF00D;
      run_op("R7", 1, 2'd2, 1, 1, 0, 0, 0, 0, 32'd4, 32'h0, 32'h50, 32'hCAFEF00D);
      // R6: 16-bit word scan wraps the low half of dst, count upper half kept
      dmem[8'hFF] = 32'h00004242; dmem[8'h01] = 32'h00004242;
      run_op("R6", 1, 2'd1, 0, 1, 0, 0, 0, 0, 32'hABCD0002, 32'h0, 32'h1234FFFF, 32'h4242);
      // R6/R1: count whose low 16 bits are zero is treated as empty in 16-bit mode
      run_op("R6", 1, 2'd0, 0, 1, 0, 0, 0, 0, 32'h00010000, 32'h0, 32'h9, 32'h0);
      // R6: compare downward wraps source low half
      smem[8'h00] = 32'h7; dmem[8'h33] = 32'h7;
      run_op("R6", 0, 2'd0, 0, 1, 0, 0, 0, 1, 32'h00000004, 32'h00050000, 32'h00000033, 32'h0);

      // budget and single-step tests over a uniform destination
      for (int i = 0; i < 256; i++) dmem[i] = 32'h77777777;
      // R8: small budget, slow core: 13 elements
      run_op("R8", 1, 2'd0, 1, 1, 0, 0, 0, 0, 32'd50, 32'h0, 32'h0, 32'h77);
      // R8: small budget, fast core: 21 elements
      run_op("R8", 1, 2'd0, 1, 1, 1, 0, 0, 0, 32'd50, 32'h0, 32'h3, 32'h77);
      // R8: large budget, fast core, with wait states: 201 elements
      stall = 1'b1;
      run_op("R8", 1, 2'd2, 1, 1, 1, 1, 0, 0, 32'd300, 32'h0, 32'h100, 32'h77777777);
      stall = 1'b0;
      // R9: trap stops after one element
      run_op("R9", 1, 2'd1, 1, 1, 0, 1, 1, 1, 32'd9, 32'h0, 32'h40, 32'h7777);
      // R10: not-equal repeat with equal data stops, no restart
      run_op("R10", 1, 2'd0, 1, 0, 0, 0, 0, 0, 32'd9, 32'h0, 32'h10, 32'h77);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule